// File: doc/BRIEF.md
# Scrambled-Map 64-Source Interrupt Controller

This block gathers up to 64 level-sensitive interrupt request lines into a pair of 32-bit pending registers and a pair of 32-bit enable registers, named high and low. A source does not sit at bit n of a register. A fixed permutation gives each source number one register and one bit position. Software reaches the four registers and a read-only vector register over a single-cycle register bus. Reads are combinational and writes take effect at the clock edge.

A request that is high at a clock edge sets its pending bit, whatever its enable bit holds. The bit stays set until software writes a 1 to it. If the line is still high when that write lands, the request wins and the bit stays set. The processor interrupt line is high while any pending bit is also enabled. The vector register reports the lowest-numbered source that is both pending and enabled. Source number 0 is reserved, so a vector of 0 means nothing is waiting.

The block has no state machine. All of its state is in the four registers, and the outputs are combinational decodes of them.

Top module: `irqc_scram`

## Requirements
- R1: After reset, both enable registers and both pending registers read 0, the vector register reads 0, and `irq_o` is low.
- R2: The source-to-bit map is as follows. Source 0 sits at high bit 0. Sources 1–15 sit at high bits 15 down to 1. Sources 32–47 sit at high bits 31 down to 16. Sources 16, 17 and 18 sit at low bits 2, 1 and 0. Sources 19–30 sit at low bits 14 down to 3. Source 31 sits at low bit 15. Sources 48–63 sit at low bits 16 up to 31.
- R3: A write to byte offset 0x0 loads the high enable register, and a write to 0x4 loads the low one. Each reads back at the same offset. An enable bit of 1 allows its source and 0 blocks it. Without a write, the enable registers hold their value.
- R4: A request line that is high at a clock edge sets its pending bit at that edge, whether the source is enabled or not. The bit stays set after the line drops. No pending bit sets without a request.
- R5: A write to offset 0x8 (high) or 0xC (low) clears each pending bit written with 1 and leaves each bit written with 0 unchanged.
- R6: A request that is still high at the edge of a clearing write keeps its pending bit set.
- R7: `irq_o` is high exactly when some bit is both pending and enabled. It is low in the cycle after the last such bit is cleared or blocked.
- R8: Reading offset 0x10 returns the lowest-numbered pending and enabled source in bits 31:26, with bits 25:0 at 0. It returns 0 when no such source exists.
- R9: The request of source 0 is ignored. High pending bit 0 always reads 0.
- R10: Writes to 0x10 and to unmapped offsets change no register. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | 64 | Level request lines, indexed by source number |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, a combinational decode of `bus_addr` |
| irq_o | output | 1 | Interrupt to the processor |

## Verification
The embedded assertions check four things on every cycle:
- Each request sets its pending bit at the next edge, and no pending bit sets without a request.
- A one-write clears only the bits it names that have no request behind them, and the enable registers hold without a write.
- The reserved bit stays 0.
- `irq_o` agrees with a non-zero vector, and the vector names an active source.

The correctness of the scrambled permutation, the choice of the lowest number when several sources compete, and the effect of writes to read-only or unmapped offsets show up only in the bench scenarios. There, the bench compares every source against its expected bit, and every cycle against a behavioural model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int WORD_W = 32;
    localparam int NWORD  = 2;
    localparam int NSRC   = NWORD * WORD_W;
    localparam int VEC_W  = $clog2(NSRC);
    localparam int BIT_W  = $clog2(WORD_W);

    typedef logic [NWORD-1:0][WORD_W-1:0] word_pair_t;

    // register select: 0 = high word, 1 = low word (alternates every 16 sources)
    function automatic logic [0:0] src_word(int s);
        return 1'((s >> 4) & 1);
    endfunction

    // bit position of a source inside its word
    function automatic logic [BIT_W-1:0] src_bit(int s);
        int b;
        if (s == 0)       b = 0;
        else if (s < 16)  b = 16 - s;
        else if (s < 19)  b = 18 - s;
        else if (s < 31)  b = 33 - s;
        else if (s == 31) b = 15;
        else if (s < 48)  b = 63 - s;
        else              b = s - 32;
        return BIT_W'(b);
    endfunction
endpackage

// File: rtl/irqc_bank.sv
module irqc_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req,
    input  logic         mask_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] pend_q
);
    logic [W-1:0] clr_bits;

    assign clr_bits = clr_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            pend_q <= '0;
        end else begin
            if (mask_we) mask_q <= wdata;
            // a live request outranks a clear in the same cycle
            pend_q <= (pend_q & ~clr_bits) | req;
        end
    end

    p_req_sets_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(req)) == $past(req)));

    p_no_spurious_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(req)) == '0));

    p_clear_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((pend_q & $past(wdata) & ~$past(req)) == '0));

    p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_q));
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  word_pair_t       act,
    output logic [VEC_W-1:0] vec
);
    always_comb begin
        vec = '0;
        for (int s = NSRC - 1; s >= 1; s--) begin
            if (act[src_word(s)][src_bit(s)]) vec = VEC_W'(s);
        end
    end

    p_vec_is_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec != '0) |-> act[src_word(int'(vec))][src_bit(int'(vec))]);
endmodule

// File: rtl/irqc_scram.sv
module irqc_scram
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_req,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] OFS_MASK_HI = ADDR_W'(5'h00);
    localparam logic [ADDR_W-1:0] OFS_MASK_LO = ADDR_W'(5'h04);
    localparam logic [ADDR_W-1:0] OFS_PEND_HI = ADDR_W'(5'h08);
    localparam logic [ADDR_W-1:0] OFS_PEND_LO = ADDR_W'(5'h0C);
    localparam logic [ADDR_W-1:0] OFS_VECTOR  = ADDR_W'(5'h10);

    word_pair_t        req_w, mask_w, pend_w, act_w;
    logic [VEC_W-1:0]  vec;
    logic              wr_en;

    assign wr_en = bus_sel & bus_wr;

    // scatter raw lines into register positions; source 0 is reserved
    always_comb begin
        req_w = '0;
        for (int s = 1; s < NSRC; s++) begin
            req_w[src_word(s)][src_bit(s)] = irq_req[s];
        end
    end

    for (genvar w = 0; w < NWORD; w++) begin : g_bank
        localparam logic [ADDR_W-1:0] MOFS = (w == 0) ? OFS_MASK_HI : OFS_MASK_LO;
        localparam logic [ADDR_W-1:0] POFS = (w == 0) ? OFS_PEND_HI : OFS_PEND_LO;
        irqc_bank #(.W(WORD_W)) i_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req_w[w]),
            .mask_we (wr_en && bus_addr == MOFS),
            .clr_we  (wr_en && bus_addr == POFS),
            .wdata   (bus_wdata),
            .mask_q  (mask_w[w]),
            .pend_q  (pend_w[w])
        );
        assign act_w[w] = mask_w[w] & pend_w[w];
    end

    irqc_prio i_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act_w),
        .vec   (vec)
    );

    assign irq_o = |act_w;

    always_comb begin
        unique case (bus_addr)
            OFS_MASK_HI: bus_rdata = mask_w[0];
            OFS_MASK_LO: bus_rdata = mask_w[1];
            OFS_PEND_HI: bus_rdata = pend_w[0];
            OFS_PEND_LO: bus_rdata = pend_w[1];
            OFS_VECTOR:  bus_rdata = {vec, {(WORD_W-VEC_W){1'b0}}};
            default:     bus_rdata = '0;
        endcase
    end

    p_irq_matches_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (vec != '0));

    p_src0_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_w[0][0]);
endmodule

// File: tb/test_irqc_scram.sv
module test_irqc_scram;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_req = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // independent map tables
    int          bw[64];
    int          bb[64];
    logic [31:0] mm0, mm1, mp0, mp1;

    irqc_scram i_irqc_scram (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        for (int k = 0; k < 64; k++) begin bw[k] = 0; bb[k] = 0; end
        for (int k = 1; k <= 15; k++) begin bw[k] = 0; bb[k] = 16 - k; end
        bw[16] = 1; bb[16] = 2; bw[17] = 1; bb[17] = 1; bw[18] = 1; bb[18] = 0;
        for (int k = 0; k < 12; k++) begin bw[19+k] = 1; bb[19+k] = 14 - k; end
        bw[31] = 1; bb[31] = 15;
        for (int k = 0; k < 16; k++) begin bw[32+k] = 0; bb[32+k] = 31 - k; end
        for (int k = 0; k < 16; k++) begin bw[48+k] = 1; bb[48+k] = 16 + k; end
    end

    function automatic bit m_active(int s);
        if (bw[s] == 1) return mm1[bb[s]] & mp1[bb[s]];
        return mm0[bb[s]] & mp0[bb[s]];
    endfunction

    function automatic int m_vec();
        for (int s = 1; s < 64; s++) if (m_active(s)) return s;
        return 0;
    endfunction

    function automatic logic [31:0] m_read(logic [4:0] a);
        case (a)
            5'h00: return mm0;
            5'h04: return mm1;
            5'h08: return mp0;
            5'h0C: return mp1;
            5'h10: return {6'(m_vec()), 26'b0};
            default: return 32'h0;
        endcase
    endfunction

    // behavioural reference, updated on every edge
    always @(posedge clk) begin
        logic [31:0] r0, r1;
        if (!rst_n) begin
            mm0 = 0; mm1 = 0; mp0 = 0; mp1 = 0;
        end else begin
            r0 = 0; r1 = 0;
            for (int s = 1; s < 64; s++)
                if (irq_req[s]) begin
                    if (bw[s] == 1) r1[bb[s]] = 1'b1; else r0[bb[s]] = 1'b1;
                end
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    5'h00: mm0 = bus_wdata;
                    5'h04: mm1 = bus_wdata;
                    5'h08: mp0 = mp0 & ~bus_wdata;
                    5'h0C: mp1 = mp1 & ~bus_wdata;
                    default: ;
                endcase
            end
            mp0 = mp0 | r0;
            mp1 = mp1 | r1;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7 irq per cycle", {31'b0, irq_o}, {31'b0, m_vec() != 0});
            chk("R2 read per cycle", bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_sel = 0; bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic rd(logic [4:0] a, string tag, logic [31:0] exp);
        @(negedge clk); #1;
        bus_addr = a; bus_sel = 1; bus_wr = 0;
        @(negedge clk);
        chk(tag, bus_rdata, exp);
        #1 bus_sel = 0;
    endtask

    task automatic pulse(int s);
        @(negedge clk); #1 irq_req[s] = 1'b1;
        @(negedge clk); #1 irq_req[s] = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(5'h00, "R1 mask hi", 0);
        rd(5'h04, "R1 mask lo", 0);
        rd(5'h08, "R1 pend hi", 0);
        rd(5'h0C, "R1 pend lo", 0);
        rd(5'h10, "R1 vector", 0);
        chk("R1 irq", {31'b0, irq_o}, 0);

        // R4 pending while blocked, no irq
        pulse(5);
        rd(5'h08, "R4 pend while blocked", 32'h1 << 11);
        chk("R4 no irq while blocked", {31'b0, irq_o}, 0);
        // R3 enable read back, then irq rises
        wr(5'h00, 32'hFFFF_FFFF);
        wr(5'h04, 32'hA5A5_5A5A);
        rd(5'h00, "R3 mask hi readback", 32'hFFFF_FFFF);
        rd(5'h04, "R3 mask lo readback", 32'hA5A5_5A5A);
        chk("R3 irq once enabled", {31'b0, irq_o}, 1);
        rd(5'h10, "R8 vector single", {6'd5, 26'b0});
        // R5: zero write leaves, one write clears
        wr(5'h08, 32'h0);
        rd(5'h08, "R5 zero write keeps", 32'h1 << 11);
        wr(5'h08, 32'h1 << 11);
        chk("R7 irq low after clear", {31'b0, irq_o}, 0);
        rd(5'h08, "R5 cleared", 0);
        wr(5'h04, 32'hFFFF_FFFF);

        // R2 every source to its mapped bit
        for (int s = 1; s < 64; s++) begin
            pulse(s);
            rd(bw[s] ? 5'h0C : 5'h08, "R2 map", 32'h1 << bb[s]);
            rd(5'h10, "R8 vector per source", {6'(s), 26'b0});
            wr(bw[s] ? 5'h0C : 5'h08, 32'h1 << bb[s]);
        end

        // R9 source 0 ignored
        pulse(0);
        rd(5'h08, "R9 src0 pend", 0);
        chk("R9 src0 irq", {31'b0, irq_o}, 0);

        // R8 lowest wins
        @(negedge clk); #1 irq_req[40] = 1; irq_req[22] = 1; irq_req[50] = 1;
        @(negedge clk); #1 irq_req = '0;
        rd(5'h10, "R8 lowest of three", {6'd22, 26'b0});
        wr(5'h0C, 32'h1 << 11);
        rd(5'h10, "R8 next lowest", {6'd40, 26'b0});
        // R7 blocking drops irq
        wr(5'h00, 32'h0);
        rd(5'h10, "R8 after block", {6'd50, 26'b0});
        wr(5'h04, 32'h0);
        chk("R7 irq low after block", {31'b0, irq_o}, 0);
        rd(5'h10, "R8 none", 0);

        // R6 held request survives clear
        wr(5'h04, 32'hFFFF_FFFF);
        @(negedge clk); #1 irq_req[60] = 1;
        wr(5'h0C, 32'hFFFF_FFFF);
        rd(5'h0C, "R6 held request", 32'h1 << 28);
        #1 irq_req[60] = 0;
        wr(5'h0C, 32'hFFFF_FFFF);
        rd(5'h0C, "R6 cleared after drop", 0);

        // R10 read-only and unmapped
        wr(5'h08, 32'hFFFF_FFFF);
        wr(5'h10, 32'hFFFF_FFFF);
        wr(5'h14, 32'h1234_5678);
        rd(5'h00, "R10 mask hi untouched", 0);
        rd(5'h04, "R10 mask lo untouched", 32'hFFFF_FFFF);
        rd(5'h10, "R10 vector untouched", 0);
        rd(5'h14, "R10 unmapped read", 0);
        rd(5'h1C, "R10 unmapped read 2", 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule